// File: doc/BRIEF.md
# Power-Stage Operating-Mode Sequencer

This block decides, cycle by cycle, whether the power switch of a quasi-resonant flyback controller may operate. It walks the controller through power-up, a time-stepped soft-start, normal regulation, automatic restart after an overload or a mains dip, and a permanent fault lock. Analog comparators and the overload timing capacitor live outside the block. Each of them reaches it as a single flag.

During soft-start a two-bit index selects one of four regulation references. Index n stands for 1.8 V + n x 0.55 V. Each index is held for a parameterized number of clock cycles, which is 4 ms at the intended clock. Overload sensing is masked until soft-start finishes. An overload or a mains undervoltage stops switching, and the machine later re-enters soft-start from index 0. An output-overvoltage or shorted-winding request locks the controller off, and only a supply-undervoltage reset clears that lock.

Top module: `qr_mode_seq`

## Requirements
- R1: While `vcc_uv` is high or `rst_n` is low, the block enters the off state on the next clock edge. In the off state all four outputs are 0. This takes precedence over every other input and every state.
- R2: In the off state with `vcc_uv` low, the next edge starts soft-start. Switching is enabled and `ss_step` is 0.
- R3: In soft-start, `ss_step` holds each value for exactly STEP_CYCLES cycles and then advances 0, 1, 2, 3. Code n selects the reference 1.8 V + n x 0.55 V.
- R4: After STEP_CYCLES cycles at step 3, the block enters run. In run, `ss_step` reads 3 and `olp_en` is 1. In every other state `olp_en` is 0.
- R5: `olp_hi` has no effect during soft-start. Switching continues and the step sequence is unchanged.
- R6: `olp_hi` in run stops switching on the next edge. Switching stays off until `olp_lo` is seen high, and the next edge after that restarts soft-start at step 0.
- R7: `mains_uv` in soft-start or run stops switching on the next edge. When it clears, the next edge restarts soft-start at step 0.
- R8: Any bit of `latch_req` in soft-start or run locks the block on the next edge, with `sw_en`=0 and `latched`=1. In the overload-wait or mains-wait state, `latch_req` is ignored.
- R9: Once locked, only `vcc_uv` (or reset) leaves the lock. `mains_uv`, `olp_hi`, `olp_lo` and `latch_req` have no effect on it.
- R10: In soft-start and run, when several events occur together, the order is: supply undervoltage, then latch request, then mains undervoltage, then overload.
- R11: `ss_step` reads 0 whenever switching is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_uv | input | 1 | Supply below its turn-off level |
| mains_uv | input | 1 | Mains input below its protection level |
| olp_hi | input | 1 | Overload timer crossed its upper level |
| olp_lo | input | 1 | Overload timer decayed below its lower level |
| latch_req | input | N_LATCH | Fault requests that lock the controller off (overvoltage, shorted winding) |
| sw_en | output | 1 | Switching allowed |
| ss_step | output | STEP_W | Regulation reference index |
| olp_en | output | 1 | Overload detection enabled |
| latched | output | 1 | Controller locked off |

## Verification
The soft-start sequence is observed at the cycle just before and the cycle just after every step boundary. This catches a step timer that is one cycle short or long. The three stop causes (overload, mains dip, fault request) are each applied both during soft-start and during run. Comparing these runs separates protections that are correctly masked from those that must act at once. Coincident events and stimuli applied inside the wait and lock states show whether the priority order and the "ignored here" rules hold, and whether the lock survives everything except a supply reset.

// File: rtl/qr_mode_pkg.sv
package qr_mode_pkg;

    typedef enum logic [5:0] {
        MODE_OFF   = 6'b000001,
        MODE_SS    = 6'b000010,
        MODE_RUN   = 6'b000100,
        MODE_OLW   = 6'b001000,
        MODE_MUV   = 6'b010000,
        MODE_LOCK  = 6'b100000
    } mode_t;

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
    parameter int STEP_CYCLES = 4000,
    parameter int N_STEPS     = 4,
    localparam int STEP_W     = $clog2(N_STEPS),
    localparam int CNT_W      = $clog2(STEP_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [STEP_W-1:0] step,
    output logic              last
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(STEP_CYCLES - 1);
    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(N_STEPS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d = '0;
        end else if (tmr_q.cnt == CNT_MAX) begin
            tmr_d.cnt = '0;
            if (tmr_q.step != STEP_MAX)
                tmr_d.step = tmr_q.step + 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign step = tmr_q.step;
    assign last = run && (tmr_q.step == STEP_MAX) && (tmr_q.cnt == CNT_MAX);

    // R3
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tmr_q.cnt != CNT_MAX) |=> $stable(step));

    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tmr_q.cnt == CNT_MAX && step != STEP_MAX)
            |=> step == STEP_W'($past(step) + 1'b1));

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import qr_mode_pkg::*;
#(
    parameter int N_LATCH = 2,
    parameter int N_STEPS = 4,
    localparam int STEP_W = $clog2(N_STEPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vcc_uv,
    input  logic               mains_uv,
    input  logic               olp_hi,
    input  logic               olp_lo,
    input  logic [N_LATCH-1:0] latch_req,
    input  logic               ss_last,
    input  logic [STEP_W-1:0]  ss_idx,
    output logic               ss_run,
    output logic               sw_en,
    output logic [STEP_W-1:0]  ss_step,
    output logic               olp_en,
    output logic               latched
);

    localparam logic [STEP_W-1:0] STEP_TOP = STEP_W'(N_STEPS - 1);

    typedef struct packed {
        mode_t mode;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic fault;

    assign fault = |latch_req;

    always_comb begin
        fsm_d = fsm_q;
        if (vcc_uv) begin
            fsm_d.mode = MODE_OFF;
        end else begin
            case (fsm_q.mode)
                MODE_OFF:  fsm_d.mode = MODE_SS;
                MODE_SS: begin
                    if (fault)         fsm_d.mode = MODE_LOCK;
                    else if (mains_uv) fsm_d.mode = MODE_MUV;
                    else if (ss_last)  fsm_d.mode = MODE_RUN;
                end
                MODE_RUN: begin
                    if (fault)         fsm_d.mode = MODE_LOCK;
                    else if (mains_uv) fsm_d.mode = MODE_MUV;
                    else if (olp_hi)   fsm_d.mode = MODE_OLW;
                end
                MODE_OLW:  if (olp_lo)    fsm_d.mode = MODE_SS;
                MODE_MUV:  if (!mains_uv) fsm_d.mode = MODE_SS;
                MODE_LOCK: fsm_d.mode = MODE_LOCK;
                default:   fsm_d.mode = MODE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{mode: MODE_OFF};
        else        fsm_q <= fsm_d;
    end

    assign ss_run  = (fsm_q.mode == MODE_SS);
    assign sw_en   = (fsm_q.mode == MODE_SS) || (fsm_q.mode == MODE_RUN);
    assign olp_en  = (fsm_q.mode == MODE_RUN);
    assign latched = (fsm_q.mode == MODE_LOCK);
    assign ss_step = (fsm_q.mode == MODE_RUN) ? STEP_TOP :
                     (fsm_q.mode == MODE_SS)  ? ss_idx   : '0;

    // one-hot state encoding
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(fsm_q.mode));

    // R1
    uv_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_uv |=> (fsm_q.mode == MODE_OFF));

    // R5
    ss_ignores_olp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == MODE_SS && !vcc_uv && !fault && !mains_uv && !ss_last)
            |=> (fsm_q.mode == MODE_SS));

    // R6
    olw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == MODE_OLW && !vcc_uv && !olp_lo) |=> !sw_en);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == MODE_LOCK && !vcc_uv) |=> latched);

    // R8
    fault_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && fault && !vcc_uv) |=> latched);

endmodule

// File: rtl/qr_mode_seq.sv
module qr_mode_seq #(
    parameter int STEP_CYCLES = 4000,
    parameter int N_STEPS     = 4,
    parameter int N_LATCH     = 2,
    localparam int STEP_W     = $clog2(N_STEPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vcc_uv,
    input  logic               mains_uv,
    input  logic               olp_hi,
    input  logic               olp_lo,
    input  logic [N_LATCH-1:0] latch_req,
    output logic               sw_en,
    output logic [STEP_W-1:0]  ss_step,
    output logic               olp_en,
    output logic               latched
);

    logic              ss_run;
    logic              ss_last;
    logic [STEP_W-1:0] ss_idx;

    ss_step_timer #(
        .STEP_CYCLES (STEP_CYCLES),
        .N_STEPS     (N_STEPS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ss_run),
        .step  (ss_idx),
        .last  (ss_last)
    );

    mode_fsm #(
        .N_LATCH (N_LATCH),
        .N_STEPS (N_STEPS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vcc_uv    (vcc_uv),
        .mains_uv  (mains_uv),
        .olp_hi    (olp_hi),
        .olp_lo    (olp_lo),
        .latch_req (latch_req),
        .ss_last   (ss_last),
        .ss_idx    (ss_idx),
        .ss_run    (ss_run),
        .sw_en     (sw_en),
        .ss_step   (ss_step),
        .olp_en    (olp_en),
        .latched   (latched)
    );

endmodule

// File: tb/test_qr_mode_seq.sv
module test_qr_mode_seq;

    localparam int CLK_PERIOD = 10;
    localparam int S          = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vcc_uv = 1'b1;
    logic       mains_uv = 1'b0;
    logic       olp_hi = 1'b0;
    logic       olp_lo = 1'b0;
    logic [1:0] latch_req = 2'b00;
    logic       sw_en, olp_en, latched;
    logic [1:0] ss_step;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qr_mode_seq #(.STEP_CYCLES(S), .N_STEPS(4), .N_LATCH(2)) i_qr_mode_seq (
        .clk(clk), .rst_n(rst_n), .vcc_uv(vcc_uv), .mains_uv(mains_uv),
        .olp_hi(olp_hi), .olp_lo(olp_lo), .latch_req(latch_req),
        .sw_en(sw_en), .ss_step(ss_step), .olp_en(olp_en), .latched(latched)
    );

    // expected bundle: {sw_en, olp_en, latched, ss_step[1:0]}
    localparam logic [4:0] E_OFF  = 5'b000_00;
    localparam logic [4:0] E_LOCK = 5'b001_00;
    localparam logic [4:0] E_RUN  = 5'b110_11;

    function automatic logic [4:0] e_ss(input logic [1:0] st);
        return {3'b100, st};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {sw_en, olp_en, latched, ss_step};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // power up from the off state; returns at soft-start step 0, first cycle
    task automatic bring_up();
        vcc_uv = 1'b1; tick(2);
        vcc_uv = 1'b0; tick(1);
    endtask

    task automatic t_reset();
        check("R1 reset", E_OFF);
        rst_n = 1'b1; tick(3);
        check("R1 held off by vcc_uv", E_OFF);
    endtask

    task automatic t_softstart();
        bring_up();
        check("R2 start step0", e_ss(2'd0));
        tick(S-1); check("R3 step0 last cycle", e_ss(2'd0));
        tick(1);   check("R3 step1", e_ss(2'd1));
        tick(S);   check("R3 step2", e_ss(2'd2));
        tick(S-1); check("R3 step2 last cycle", e_ss(2'd2));
        tick(1);   check("R3 step3", e_ss(2'd3));
        tick(S-1); check("R4 not yet run", e_ss(2'd3));
        tick(1);   check("R4 run", E_RUN);
    endtask

    task automatic t_olp_in_ss();
        bring_up();
        olp_hi = 1'b1; tick(3);
        check("R5 olp ignored in soft-start", e_ss(2'd0));
        tick(S);
        check("R5 steps continue", e_ss(2'd1));
        olp_hi = 1'b0;
        tick(3*S-3);
        check("R5 reaches run", E_RUN);
    endtask

    task automatic t_overload();
        olp_hi = 1'b1; tick(1);
        check("R6 overload stops", E_OFF);
        olp_hi = 1'b0; tick(5);
        check("R6 waits for olp_lo R11", E_OFF);
        latch_req = 2'b01; tick(1);
        check("R8 fault ignored in wait", E_OFF);
        latch_req = 2'b00;
        olp_lo = 1'b1; tick(1);
        check("R6 restart step0", e_ss(2'd0));
        olp_lo = 1'b0; tick(4*S);
        check("R6 back to run", E_RUN);
    endtask

    task automatic t_mains();
        mains_uv = 1'b1; tick(1);
        check("R7 mains stop in run", E_OFF);
        tick(3);
        check("R7 mains hold R11", E_OFF);
        mains_uv = 1'b0; tick(1);
        check("R7 resume step0", e_ss(2'd0));
        tick(S);
        check("R7 mid soft-start step1", e_ss(2'd1));
        mains_uv = 1'b1; tick(1);
        check("R7 mains stop in soft-start", E_OFF);
        mains_uv = 1'b0; tick(1);
        check("R7 restart from step0", e_ss(2'd0));
        tick(4*S);
        check("R7 back to run", E_RUN);
    endtask

    task automatic t_latch();
        latch_req = 2'b01; tick(1);
        check("R8 lock from run", E_LOCK);
        latch_req = 2'b00;
        mains_uv = 1'b1; olp_hi = 1'b1; tick(2);
        mains_uv = 1'b0; olp_hi = 1'b0; olp_lo = 1'b1; tick(3);
        olp_lo = 1'b0; tick(1);
        check("R9 lock holds", E_LOCK);
        vcc_uv = 1'b1; tick(1);
        check("R9 supply reset clears lock", E_OFF);
        vcc_uv = 1'b0; tick(1);
        check("R2 restart after lock", e_ss(2'd0));
        tick(S+2);
        latch_req = 2'b10; tick(1);
        check("R8 lock from soft-start", E_LOCK);
        latch_req = 2'b00;
    endtask

    task automatic t_priority();
        bring_up(); tick(4*S);
        check("R10 setup run", E_RUN);
        latch_req = 2'b10; mains_uv = 1'b1; olp_hi = 1'b1; tick(1);
        check("R10 fault beats mains and overload", E_LOCK);
        latch_req = 2'b00; olp_hi = 1'b0; mains_uv = 1'b0;
        bring_up(); tick(4*S);
        mains_uv = 1'b1; olp_hi = 1'b1; tick(1);
        check("R10 mains beats overload", E_OFF);
        olp_hi = 1'b0; olp_lo = 1'b1; tick(2);
        check("R10 mains wait ignores olp_lo", E_OFF);
        olp_lo = 1'b0; mains_uv = 1'b0; tick(1 + 4*S);
        check("R10 recovered run", E_RUN);
        vcc_uv = 1'b1; latch_req = 2'b11; mains_uv = 1'b1; tick(1);
        check("R1 supply beats all", E_OFF);
        latch_req = 2'b00; mains_uv = 1'b0;
        vcc_uv = 1'b0; tick(S+3);
        vcc_uv = 1'b1; tick(1);
        check("R1 supply loss in soft-start", E_OFF);
        vcc_uv = 1'b0;
    endtask

    initial begin
        tick(1);
        t_reset();
        t_softstart();
        t_olp_in_ss();
        t_overload();
        t_mains();
        t_latch();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule